// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter

This block is the transmit half of a clock-synchronous serial port that acts as the clock master. A processor-side write strobe places a byte in a holding buffer. When the shifter is free, transmission is enabled and the peer allows it, the byte passes through an optional inversion and bit-order stage into the shift register. It then leaves on the data line, one bit per serial clock period.

The serial clock comes from a reloading half-period counter. That counter advances on a count source picked from three prescaled versions of the system clock. Between bytes the serial clock rests high. Data changes on each falling edge and is stable across each rising edge, where the receiver samples it.

A synchronised, active-low clear-to-send input is checked at each byte boundary. The transmit-enable bit is also checked at each byte boundary. Neither can cut a byte short. Status outputs show whether the buffer is free and whether the shifter has drained. An interrupt request flag is raised by either of those two events, as selected, and stays set until acknowledged.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset, `sclk_out`, `sdata_out`, `buf_empty` and `shift_empty` are 1 and `irq` is 0.
- R2: One serial bit lasts 2(`div_m`+1) count-source ticks. For `src_sel` 0 a tick is every clock, for 1 every 8 clocks, and for 2 or 3 every 32 clocks.
- R3: `sclk_out` is high whenever no byte is being shifted. `sdata_out` changes only on a falling edge of `sclk_out`, and each byte gives exactly 8 rising edges.
- R4: With `msb_first`=0 the byte goes out bit 0 first. With `msb_first`=1 it goes out bit 7 first.
- R5: With `invert`=1 every transmitted bit is the complement of the written bit.
- R6: A write clears `buf_empty` on the next edge. The move into the shifter sets it again. A byte written before the current byte ends follows it with no change in the rising-edge spacing.
- R7: `shift_empty` goes to 1 only after the eighth rising edge of a byte when no next byte starts. It returns to 0 when a byte is loaded.
- R8: While the synchronised `cts_n` is 1 and `cts_ignore` is 0, no byte starts and `sclk_out` stays high. With `cts_ignore`=1, `cts_n` has no effect.
- R9: Clearing `tx_en` during a byte lets that byte finish. No further byte starts, so a pending byte stays in the buffer until `tx_en` returns to 1.
- R10: With `irq_sel`=0, `irq` is set when a byte moves into the shifter. With `irq_sel`=1, it is set when `shift_empty` becomes 1. Once set, `irq` stays high until `irq_ack`.
- R11: `div_m`=0 gives the fastest rate of 2 count-source ticks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Count source: 0 = clock, 1 = clock/8, 2 or 3 = clock/32 |
| div_m | input | 8 | Half-period divider value m |
| tx_en | input | 1 | Transmit enable, checked at byte boundaries |
| cts_n | input | 1 | Active-low clear-to-send from the peer (asynchronous) |
| cts_ignore | input | 1 | 1 = do not check clear-to-send |
| invert | input | 1 | 1 = complement transmitted data |
| msb_first | input | 1 | 1 = send bit 7 first |
| irq_sel | input | 1 | Interrupt trigger: 0 = buffer empty, 1 = shifter empty |
| irq_ack | input | 1 | Clears the interrupt request |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| sclk_out | output | 1 | Serial clock, idles high |
| sdata_out | output | 1 | Serial data |
| buf_empty | output | 1 | Transmit buffer free |
| shift_empty | output | 1 | Shifter drained, nothing pending |
| irq | output | 1 | Pending interrupt request |

## Verification
A write is visible on `buf_empty` one clock edge later. The load into the shifter follows on the next edge, so `buf_empty` and a buffer-empty `irq` are sampled two falling clock edges after the write strobe. Serial bits and bit spacing are taken by a monitor at each rising `sclk_out` edge. Each interval is compared with exactly 2(m+1) times the prescale factor times 20 ns. Negative results, such as no pulses while clear-to-send is blocked and a byte held back after `tx_en` drops, are checked after a wait of many bit times. Before that wait, the monitor's edge count is cleared.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int DW    = 8;
    localparam int IDX_W = $clog2(DW);

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } sst_state_e;

    typedef struct packed {
        logic invert;
        logic msb_first;
    } sst_fmt_t;

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } sst_buf_t;

    // Apply bit-order reversal, then optional complement.
    function automatic logic [DW-1:0] sst_shape(input logic [DW-1:0] d, input sst_fmt_t f);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) begin
            r[i] = f.msb_first ? d[DW-1-i] : d[i];
        end
        return f.invert ? ~r : r;
    endfunction

endpackage

// File: rtl/sst_prescaler.sv
module sst_prescaler #(
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel,
    output logic       tick
);
    logic [1:0] slow_tick;

    for (genvar g = 0; g < 2; g++) begin : g_div
        localparam int D  = (g == 0) ? DIV_MID : DIV_SLOW;
        localparam int CW = $clog2(D + 1);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= '0;
            end else if (cnt == CW'(D - 1)) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end

        assign slow_tick[g] = (cnt == CW'(D - 1));
    end

    always_comb begin
        unique case (src_sel)
            2'd0:    tick = 1'b1;
            2'd1:    tick = slow_tick[0];
            default: tick = slow_tick[1];
        endcase
    end

endmodule

// File: rtl/sst_bitclock.sv
module sst_bitclock #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m,
    output logic             half_evt
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= div_m;
        end else if (tick) begin
            cnt <= (cnt == '0) ? div_m : cnt - 1'b1;
        end
    end

    assign half_evt = run && tick && (cnt == '0);

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          half_evt,
    input  logic          tx_en,
    input  logic          cts_ok,
    input  sst_fmt_t      fmt,
    input  logic          irq_sel,
    input  logic          irq_ack,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          running,
    output logic          sclk_out,
    output logic          sdata_out,
    output logic          buf_empty,
    output logic          shift_empty,
    output logic          irq
);
    sst_state_e       state;
    sst_buf_t         hold;
    logic [DW-1:0]    shreg;
    logic [IDX_W-1:0] bit_idx;
    logic             sclk_q, sdata_q, sempty_q, irq_q;
    logic             can_start, at_boundary, load, drain;

    assign can_start   = hold.full && tx_en && cts_ok;
    assign at_boundary = (state == ST_SHIFT) && half_evt && !sclk_q && (bit_idx == IDX_W'(DW - 1));
    assign load        = can_start && ((state == ST_IDLE) || at_boundary);
    assign drain       = at_boundary && !can_start;

    // Transmit buffer: a same-cycle write wins over the load that empties it.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (wr_en) begin
            hold.full <= 1'b1;
            hold.data <= wr_data;
        end else if (load) begin
            hold.full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            sclk_q   <= 1'b1;
            sdata_q  <= 1'b1;
            sempty_q <= 1'b1;
        end else begin
            if (load) begin
                state    <= ST_SHIFT;
                shreg    <= sst_shape(hold.data, fmt);
                bit_idx  <= '0;
                sempty_q <= 1'b0;
            end else if (drain) begin
                state    <= ST_IDLE;
                sempty_q <= 1'b1;
            end else if (state == ST_SHIFT && half_evt && !sclk_q) begin
                bit_idx <= bit_idx + 1'b1;
            end
            if (state == ST_SHIFT && half_evt) begin
                sclk_q <= !sclk_q;
                if (sclk_q) begin
                    sdata_q <= shreg[bit_idx];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if ((irq_sel == 1'b0) ? load : drain) begin
            irq_q <= 1'b1;
        end else if (irq_ack) begin
            irq_q <= 1'b0;
        end
    end

    assign running     = (state == ST_SHIFT);
    assign sclk_out    = sclk_q;
    assign sdata_out   = sdata_q;
    assign buf_empty   = !hold.full;
    assign shift_empty = sempty_q;
    assign irq         = irq_q;

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> sclk_q);  // R3
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$fell(sclk_q) |-> $stable(sdata_q));  // R3
    AST_DRAINED_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
        sempty_q |-> (state == ST_IDLE));  // R7
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_ack) |=> irq_q);  // R10
    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SHIFT) && $past(state == ST_IDLE)) |-> $past(tx_en && cts_ok));  // R8

endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
    import sst_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] div_m,
    input  logic             tx_en,
    input  logic             cts_n,
    input  logic             cts_ignore,
    input  logic             invert,
    input  logic             msb_first,
    input  logic             irq_sel,
    input  logic             irq_ack,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic             sclk_out,
    output logic             sdata_out,
    output logic             buf_empty,
    output logic             shift_empty,
    output logic             irq
);
    logic [1:0] cts_sync;
    logic       tick, half_evt, running, cts_ok;
    sst_fmt_t   fmt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_sync <= 2'b11;
        end else begin
            cts_sync <= {cts_sync[0], cts_n};
        end
    end

    assign cts_ok = cts_ignore || !cts_sync[1];
    assign fmt    = '{invert: invert, msb_first: msb_first};

    sst_prescaler #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_pre (
        .clk(clk), .rst(rst), .src_sel(src_sel), .tick(tick)
    );

    sst_bitclock #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst(rst), .tick(tick), .run(running),
        .div_m(div_m), .half_evt(half_evt)
    );

    sst_shifter u_shift (
        .clk(clk), .rst(rst), .half_evt(half_evt), .tx_en(tx_en),
        .cts_ok(cts_ok), .fmt(fmt), .irq_sel(irq_sel), .irq_ack(irq_ack),
        .wr_en(wr_en), .wr_data(wr_data), .running(running),
        .sclk_out(sclk_out), .sdata_out(sdata_out), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    AST_EVT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_out) |-> $past(tick));  // R2

endmodule

// File: tb/tb_sync_serial_tx.sv
module tb_sync_serial_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'd0;
    logic [7:0] div_m = 8'd0;
    logic       tx_en = 1'b0, cts_n = 1'b0, cts_ignore = 1'b0;
    logic       invert = 1'b0, msb_first = 1'b0, irq_sel = 1'b0, irq_ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       sclk_out, sdata_out, buf_empty, shift_empty, irq;

    int checks = 0;
    int errors = 0;
    int n_rise = 0;
    logic  rbits [0:63];
    time   rtime [0:63];

    always #10 clk = ~clk;

    sync_serial_tx dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .div_m(div_m), .tx_en(tx_en),
        .cts_n(cts_n), .cts_ignore(cts_ignore), .invert(invert), .msb_first(msb_first),
        .irq_sel(irq_sel), .irq_ack(irq_ack), .wr_en(wr_en), .wr_data(wr_data),
        .sclk_out(sclk_out), .sdata_out(sdata_out), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    always @(posedge sclk_out) begin
        if (n_rise < 64) begin
            rbits[n_rise] = sdata_out;
            rtime[n_rise] = $time;
        end
        n_rise = n_rise + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_drain();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            if (shift_empty) break;
            @(negedge clk);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] d, input int i, input logic msb, input logic inv);
        return d[msb ? 7 - i : i] ^ inv;
    endfunction

    task automatic check_byte(input logic [7:0] d, input int base, input string req);
        logic [7:0] got, exp;
        for (int i = 0; i < 8; i++) begin
            got[i] = rbits[base + i];
            exp[i] = exp_bit(d, i, msb_first, invert);
        end
        chk(got == exp, req, got, exp);
    endtask

    task automatic send_one(input logic [7:0] d, input string req);
        n_rise = 0;
        put(d);
        wait_drain();
        chk(n_rise == 8, "R3 pulse count", n_rise, 8);
        check_byte(d, 0, req);
    endtask

    task automatic t_reset();
        chk(sclk_out == 1'b1, "R1 sclk", sclk_out, 1);
        chk(sdata_out == 1'b1, "R1 sdata", sdata_out, 1);
        chk(buf_empty && shift_empty, "R1 empties", {buf_empty, shift_empty}, 3);
        chk(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_order();
        tx_en = 1'b1; div_m = 8'd0; src_sel = 2'd0;
        send_one(8'hA5, "R4 lsb first");
        chk(rtime[1] - rtime[0] == 40, "R11 m=0 spacing", rtime[1] - rtime[0], 40);
        msb_first = 1'b1;
        send_one(8'h1C, "R4 msb first");
        invert = 1'b1;
        send_one(8'h1C, "R5 invert msb");
        msb_first = 1'b0;
        send_one(8'h3B, "R5 invert lsb");
        invert = 1'b0;
        chk(sclk_out == 1'b1, "R3 idle high", sclk_out, 1);
    endtask

    task automatic t_rate(input logic [1:0] s, input logic [7:0] m, input int pre);
        src_sel = s; div_m = m;
        send_one(8'h69, "R2 data");
        chk(rtime[7] - rtime[6] == time'(2 * (m + 1) * pre * 20), "R2 period",
            rtime[7] - rtime[6], 2 * (m + 1) * pre * 20);
        src_sel = 2'd0; div_m = 8'd0;
    endtask

    task automatic t_buffer();
        div_m = 8'd1;
        tx_en = 1'b0;
        put(8'hC3);
        chk(buf_empty == 1'b0, "R6 write clears", buf_empty, 0);
        n_rise = 0;
        tx_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(buf_empty == 1'b1, "R6 load sets", buf_empty, 1);
        chk(shift_empty == 1'b0, "R7 busy", shift_empty, 0);
        put(8'h5E);
        wait_drain();
        chk(n_rise == 16, "R6 two bytes", n_rise, 16);
        check_byte(8'hC3, 0, "R6 first");
        check_byte(8'h5E, 8, "R6 second");
        chk(rtime[8] - rtime[7] == rtime[1] - rtime[0], "R6 no gap",
            rtime[8] - rtime[7], rtime[1] - rtime[0]);
        chk(shift_empty && buf_empty, "R7 drained", {shift_empty, buf_empty}, 3);
    endtask

    task automatic t_cts();
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        n_rise = 0;
        put(8'h81);
        repeat (200) @(negedge clk);
        chk(n_rise == 0, "R8 blocked pulses", n_rise, 0);
        chk(sclk_out == 1'b1 && !buf_empty, "R8 blocked state", {sclk_out, buf_empty}, 2);
        chk(shift_empty == 1'b1, "R7 nothing shifted", shift_empty, 1);
        cts_ignore = 1'b1;
        wait_drain();
        chk(n_rise == 8, "R8 ignore sends", n_rise, 8);
        check_byte(8'h81, 0, "R8 data");
        cts_ignore = 1'b0;
        cts_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_disable();
        div_m = 8'd2;
        n_rise = 0;
        put(8'h0F);
        repeat (3) @(negedge clk);
        put(8'hF0);
        for (int i = 0; i < 2000 && n_rise < 3; i++) @(negedge clk);
        tx_en = 1'b0;
        repeat (400) @(negedge clk);
        chk(n_rise == 8, "R9 byte finishes", n_rise, 8);
        chk(!buf_empty && shift_empty, "R9 pending kept", {buf_empty, shift_empty}, 1);
        check_byte(8'h0F, 0, "R9 first");
        tx_en = 1'b1;
        wait_drain();
        chk(n_rise == 16, "R9 resumes", n_rise, 16);
        check_byte(8'hF0, 8, "R9 second");
        div_m = 8'd0;
    endtask

    task automatic t_irq();
        irq_sel = 1'b0;
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(irq == 1'b0, "R10 cleared", irq, 0);
        tx_en = 1'b0;
        put(8'h33);
        chk(irq == 1'b0, "R10 no load yet", irq, 0);
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R10 buffer empty irq", irq, 1);
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R10 held", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        wait_drain();
        chk(irq == 1'b0, "R10 sel0 no drain irq", irq, 0);
        irq_sel = 1'b1;
        put(8'h44);
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R10 sel1 no load irq", irq, 0);
        wait_drain();
        @(negedge clk);
        chk(irq == 1'b1, "R10 shifter empty irq", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(irq == 1'b0, "R10 ack", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_rate(2'd0, 8'd2, 1);
        t_rate(2'd1, 8'd1, 8);
        t_rate(2'd2, 8'd0, 32);
        t_buffer();
        t_cts();
        t_disable();
        t_irq();
        summary();
    end

endmodule